// File: doc/BRIEF.md
# Byte-Memory Serial Configuration Loader

This block fetches a configuration image from a byte-wide external memory and sends it out bit by bit on a serial line that feeds a chain of downstream devices. A start pulse sets the memory address to zero and captures a byte count. The block then reads one byte per read-clock period, stepping the address by one each time. Each byte goes out most significant bit first, one bit per configuration-clock period. When the last byte has been sent, the block raises a done flag and stops both clocks.

Everything runs from one system clock `clk_i`. The configuration clock is `clk_i` divided by two and has a 50 % duty cycle. The read clock is one eighth of the configuration clock, so one read period covers exactly one byte. The serial output changes only where the configuration clock falls, so a downstream device can sample it on the rising edge. The first read period after a start is a fetch-only period: `cclk_o` stays low while the first byte is read from address 0.

Top module: `cfg_loader`

## Requirements
- R1: While `rst_i` is high, and on each cycle after a reset edge until the next start, `addr_o` is 0 and `rclk_o`, `cclk_o`, `sdo_o` and `done_o` are all 0.
- R2: A start edge sets `addr_o` to 0. For the next 16 clock cycles (the fetch period) `addr_o` stays 0 and `cclk_o` and `sdo_o` stay low.
- R3: `rdata_i` is sampled on the clock edge that ends each read period (16 clock cycles). The byte used for stream position k is the one presented for address k. `addr_o` steps by exactly one at each sample and holds otherwise.
- R4: Each byte is sent most significant bit first, with each bit held for one configuration-clock period. After a falling edge of `cclk_o`, `sdo_o` changes only on the next falling edge.
- R5: While bytes are being sent, `cclk_o` is high on the odd cycles of each 16-cycle read period and low on the even ones. `rclk_o` is high in cycles 8 to 15 of each read period, so exactly 8 rising `cclk_o` edges fall between two rising `rclk_o` edges. `cclk_o` is low whenever no byte is being sent.
- R6: For a byte count N of 1 or more, `done_o` rises 16·(N+1) clock cycles after the start edge. From then on `addr_o` holds N and `cclk_o`, `rclk_o` and `sdo_o` stay low until the next start or reset.
- R7: A start with a byte count of 0 raises `done_o` on the start edge. No configuration clock is produced.
- R8: A start while a load is in progress abandons that load. The new load then behaves exactly as one started from idle.
- R9: `count_i` is captured at the start edge. Changes to it during a load do not affect when the load ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, twice the configuration-clock rate |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Synchronous start/restart pulse |
| count_i | input | ADDR_W (20) | Number of bytes to load, captured at start |
| addr_o | output | ADDR_W (20) | Memory byte address |
| rdata_i | input | DATA_W (8) | Byte read from memory at `addr_o` |
| rclk_o | output | 1 | Memory read clock, one eighth of `cclk_o` |
| cclk_o | output | 1 | Configuration clock to the serial chain |
| sdo_o | output | 1 | Serial configuration data, changes on `cclk_o` falling |
| done_o | output | 1 | Load complete |

## Verification
A phase counter that slips shows up on `cclk_o` and `rclk_o` within one clock cycle, and on `sdo_o` at the next bit boundary. A wrong address step or a wrong byte-end decision shows up as a wrong `addr_o` at the next read-period end, and as wrong serial bits during the following 16 cycles. A wrong limit compare moves the rise of `done_o` by a whole read period. The bench compares every output on every cycle against a model it computes on its own, so any such fault is reported in the cycle where it first appears.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_PRIME = 2'd1,
    LD_SHIFT = 2'd2,
    LD_DONE  = 2'd3
  } ld_state_e;

  // last phase of a read period
  function automatic logic phase_is_last(input int unsigned ph, input int unsigned phases);
    return ph == phases - 1;
  endfunction

  // odd phases end with a configuration-clock fall; the last one reloads instead
  function automatic logic phase_is_shift(input int unsigned ph, input int unsigned phases);
    return (ph % 2 == 1) && (ph != phases - 1);
  endfunction

endpackage

// File: rtl/cfgl_phase.sv
module cfgl_phase #(
  parameter int DATA_W = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             clear,
  input  logic                             run,
  output logic [$clog2(2*DATA_W)-1:0]      ph,
  output logic                             ev_end,
  output logic                             ev_shift
);
  import cfgl_pkg::*;

  localparam int PHASES = 2 * DATA_W;
  localparam int PH_W   = $clog2(PHASES);

  always_ff @(posedge clk) begin
    if (rst || clear)  ph <= '0;
    else if (run)      ph <= ph + PH_W'(1);
    else               ph <= '0;
  end

  assign ev_end   = run && phase_is_last(int'(ph), PHASES);
  assign ev_shift = run && phase_is_shift(int'(ph), PHASES);

endmodule

// File: rtl/cfgl_addr.sv
module cfgl_addr #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              inc,
  input  logic [ADDR_W-1:0] limit,
  output logic [ADDR_W-1:0] addr,
  output logic              at_limit
);

  always_ff @(posedge clk) begin
    if (rst || clear) addr <= '0;
    else if (inc)     addr <= addr + ADDR_W'(1);
  end

  assign at_limit = (addr == limit);

endmodule

// File: rtl/cfgl_shift.sv
module cfgl_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] din,
  output logic              msb
);

  logic [DATA_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst || clear) sr <= '0;
    else if (load)    sr <= din;
    else if (shift)   sr <= {sr[DATA_W-2:0], 1'b0};
  end

  assign msb = sr[DATA_W-1];

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] count_i,
  output logic [ADDR_W-1:0] addr_o,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              rclk_o,
  output logic              cclk_o,
  output logic              sdo_o,
  output logic              done_o
);
  import cfgl_pkg::*;

  localparam int PHASES = 2 * DATA_W;
  localparam int PH_W   = $clog2(PHASES);

  ld_state_e         state_q, state_d;
  logic [ADDR_W-1:0] limit_q;
  logic [PH_W-1:0]   ph;
  logic              ev_end, ev_shift, at_limit, sr_msb;

  // named internal events
  logic running, shifting, ev_load, ev_finish, ev_sh, sr_clear;

  assign running   = (state_q == LD_PRIME) || (state_q == LD_SHIFT);
  assign shifting  = (state_q == LD_SHIFT);
  assign ev_load   = !start_i && ev_end && ((state_q == LD_PRIME) || (shifting && !at_limit));
  assign ev_finish = !start_i && ev_end && shifting && at_limit;
  assign ev_sh     = !start_i && shifting && ev_shift;
  assign sr_clear  = start_i || ev_finish;

  always_comb begin
    state_d = state_q;
    if (start_i)
      state_d = (count_i == '0) ? LD_DONE : LD_PRIME;
    else if (ev_end && state_q == LD_PRIME)
      state_d = LD_SHIFT;
    else if (ev_finish)
      state_d = LD_DONE;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= LD_IDLE;
      limit_q <= '0;
    end else begin
      state_q <= state_d;
      if (start_i) limit_q <= count_i;
    end
  end

  cfgl_phase #(.DATA_W(DATA_W)) u_phase (
    .clk(clk_i), .rst(rst_i), .clear(start_i), .run(running),
    .ph(ph), .ev_end(ev_end), .ev_shift(ev_shift)
  );

  cfgl_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk_i), .rst(rst_i), .clear(start_i), .inc(ev_load),
    .limit(limit_q), .addr(addr_o), .at_limit(at_limit)
  );

  cfgl_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk_i), .rst(rst_i), .clear(sr_clear), .load(ev_load),
    .shift(ev_sh), .din(rdata_i), .msb(sr_msb)
  );

  assign rclk_o = running && ph[PH_W-1];
  assign cclk_o = shifting && ph[0];
  assign sdo_o  = sr_msb;
  assign done_o = (state_q == LD_DONE);

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [ADDR_W-1:0] addr,
  input logic              rclk,
  input logic              cclk,
  input logic              sdo,
  input logic              done,
  input logic              shifting
);
  localparam int CW = $clog2(DATA_W) + 2;

  logic          rclk_d, cclk_d, armed;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rclk_d <= 1'b0;
      cclk_d <= 1'b0;
    end else begin
      rclk_d <= rclk;
      cclk_d <= cclk;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !shifting) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (rclk && !rclk_d) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (cclk && !cclk_d) begin
      cnt <= cnt + CW'(1);
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (addr == '0 && !rclk && !cclk && !sdo && !done));

  a_r2_start_zero: assert property (@(posedge clk) disable iff (rst)
    start |=> (addr == '0 && !cclk));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    !start |=> (addr == $past(addr) || addr == $past(addr) + ADDR_W'(1)));

  a_r4_sdo_on_fall: assert property (@(posedge clk) disable iff (rst)
    (shifting && $past(shifting) && sdo != $past(sdo)) |-> ($past(cclk) && !cclk));

  a_r5_cclk_gated: assert property (@(posedge clk) disable iff (rst)
    !shifting |-> !cclk);

  a_r5_ratio: assert property (@(posedge clk) disable iff (rst)
    (shifting && armed && rclk && !rclk_d) |-> (cnt == CW'(DATA_W)));

  a_r6_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> (!cclk && !rclk && !sdo));

  a_r6_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && addr == $past(addr)));

endmodule

bind cfg_loader cfg_loader_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk_i), .rst(rst_i), .start(start_i), .addr(addr_o), .rclk(rclk_o),
  .cclk(cclk_o), .sdo(sdo_o), .done(done_o), .shifting(shifting)
);

// File: tb/tb_cfg_loader.sv
module tb_cfg_loader;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 8;

  // vector: {byte count, memory seed}
  localparam int NV = 6;
  localparam logic [27:0] VEC [NV] = '{
    {20'd1, 8'hA5}, {20'd2, 8'h3C}, {20'd3, 8'h00},
    {20'd5, 8'hFF}, {20'd7, 8'h96}, {20'd12, 8'h4E}
  };

  logic              clk = 1'b0;
  logic              rst_i = 1'b1;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] count_i = '0;
  logic [ADDR_W-1:0] addr_o;
  logic [DATA_W-1:0] rdata_i;
  logic              rclk_o, cclk_o, sdo_o, done_o;
  logic [7:0]        seed_q = 8'h00;

  int nvec = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] membyte(input logic [7:0] seed, input int a);
    int v;
    v = (a * 29) ^ int'(seed) ^ (a >> 3);
    return v[7:0];
  endfunction

  always_comb rdata_i = membyte(seed_q, int'(addr_o));

  cfg_loader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_i(rst_i), .start_i(start_i), .count_i(count_i),
    .addr_o(addr_o), .rdata_i(rdata_i), .rclk_o(rclk_o), .cclk_o(cclk_o),
    .sdo_o(sdo_o), .done_o(done_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_check(input string req);
    chk(req, int'(addr_o), 0);
    chk(req, int'({rclk_o, cclk_o, sdo_o, done_o}), 0);
  endtask

  // start a load; compare every output every cycle up to stop_n (or to the end)
  task automatic run_stream(input int cnt, input logic [7:0] seed, input int stop_n,
                            input int cnt_late, input string tag);
    int fin;
    int e_addr, e_sdo, e_cclk, e_rclk, e_done, b, q;
    logic [7:0] byt;
    fin = (cnt == 0) ? 0 : 16 * (cnt + 1);
    @(negedge clk);
    seed_q  = seed;
    count_i = ADDR_W'(cnt);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    count_i = ADDR_W'(cnt_late);
    for (int n = 0; ; n++) begin
      if (n > 0) @(negedge clk);
      if (n >= fin) begin
        e_addr = cnt; e_sdo = 0; e_cclk = 0; e_rclk = 0; e_done = 1;
      end else if (n < 16) begin
        e_addr = 0; e_sdo = 0; e_cclk = 0; e_rclk = (n >= 8) ? 1 : 0; e_done = 0;
      end else begin
        b = (n - 16) / 16;
        q = n % 16;
        byt = membyte(seed, b);
        e_addr = b + 1;
        e_sdo  = int'(byt[7 - q / 2]);
        e_cclk = q % 2;
        e_rclk = (q >= 8) ? 1 : 0;
        e_done = 0;
      end
      chk((n < 16) ? "R2 addr" : "R3 addr", int'(addr_o), e_addr);
      chk("R4 sdo", int'(sdo_o), e_sdo);
      chk("R5 cclk", int'(cclk_o), e_cclk);
      chk("R5 rclk", int'(rclk_o), e_rclk);
      chk((cnt == 0) ? "R7 done" : "R6 done", int'(done_o), e_done);
      if (stop_n >= 0 && n >= stop_n) break;
      if (stop_n < 0 && n >= fin + 2) break;
    end
    if (stop_n < 0) begin
      chk(tag, int'(done_o), 1);
      chk(tag, int'(addr_o), cnt);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    idle_check("R1 in reset");
    rst_i = 1'b0;
    repeat (5) @(negedge clk);
    idle_check("R1 after reset");

    // main table
    for (int i = 0; i < NV; i++) begin
      run_stream(int'(VEC[i][27:8]), VEC[i][7:0], -1, int'(VEC[i][27:8]), "R6 end");
    end

    // R7: zero byte count
    run_stream(0, 8'h11, -1, 0, "R7 zero count");
    repeat (4) @(negedge clk);
    chk("R7 no cclk", int'(cclk_o), 0);

    // R8: restart in the middle of a load
    run_stream(4, 8'hC3, 40, 4, "R8");
    run_stream(2, 8'h5A, -1, 2, "R8 restart");

    // R9: count change during load ignored
    run_stream(3, 8'h77, -1, 1, "R9 latched count");

    // R1: reset in the middle of a load
    run_stream(3, 8'h29, 30, 3, "R1");
    rst_i = 1'b1;
    @(negedge clk);
    idle_check("R1 mid-load reset");
    rst_i = 1'b0;
    repeat (20) @(negedge clk);
    idle_check("R1 idle after reset");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule